// File: doc/BRIEF.md
# Radix-16 Recoded Unsigned Multiplier

This block multiplies two 64-bit unsigned integers and returns the full 128-bit product. It is fully pipelined. It accepts one operand pair per clock and returns each product a fixed number of cycles later, in the order the pairs arrived.

The multiplier operand is rewritten as sixteen signed base-16 digits, each between -8 and +8. A small first stage prepares three odd multiples of the multiplicand (three, five and seven times) using ordinary adders. All even multiples are wiring shifts of these. Each digit selects one magnitude, which is inverted for a negative digit.

The increment that completes each negation is slipped into the empty low columns of the next row. The sign compensation of all rows is folded into one precomputed constant. The extra copy of the multiplicand, which unsigned recoding leaves above the top digit, shares that constant row. The rows are compressed by a carry-save tree into two words, which a final adder sums.

Top module: `booth_r16_mul`

## Requirements
- R1: For every pair of 64-bit unsigned operands, `prod_o` equals the exact 128-bit unsigned product `a_i * b_i`.
- R2: A pair accepted with `valid_i` high at a rising edge appears with `valid_o` high exactly three rising edges later, counting that edge. Pairs presented on consecutive cycles come out on consecutive cycles, in arrival order.
- R3: While `rst_n` is low, and on every cycle without a matching accepted pair, `valid_o` is low.
- R4: Digit i of `b_i` is worth -8·b[4i+3] + 4·b[4i+2] + 2·b[4i+1] + b[4i] + b[4i-1], where b[-1] is taken as 0. Multipliers that produce +8 digits (such as 0x7F7F…7F) and -8 digits (such as 0x0808…08 and 0x8080…80) still give exact products.
- R5: The top multiplier bit b[63] acts as a recoding carry worth `a_i`·2^64. Multipliers with that bit set, such as all ones or only bit 63, give exact products.
- R6: The three, five and seven times multiples of `a_i`, and the shifted even multiples, are selected correctly. Multipliers whose digits are all ±2, ±3, ±4, ±5, ±6 or 7 give exact products.
- R7: A zero on either operand gives a zero product. A one on either operand returns the other operand. All ones times all ones gives 2^128 − 2^65 + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| a_i | input | 64 | Multiplicand, unsigned |
| b_i | input | 64 | Multiplier, unsigned, recoded into digits |
| valid_o | output | 1 | Product present this cycle |
| prod_o | output | 128 | Unsigned product |

## Verification
Fixed multiplier patterns steer the recoder into a single digit value across every position. That separates faults in each multiple, each shift and the inversion path, which random data alone would mix together. The 0x7F7F…, 0x0808… and 0x8080… multipliers force the ±8 extremes. All ones and a lone bit 63 expose the recoding carry, which patterns with bit 63 clear never use. Zero, one and all-ones operands pin the sign compensation constant. A random stream with gaps and a back-to-back burst checks the ordering and the three-cycle spacing against a queue of expected products.

// File: rtl/booth_r16_pkg.sv
// Shared types and elaboration helpers for the radix-16 multiplier.
// Assumes a digit magnitude never exceeds 8, so four bits hold it.
package booth_r16_pkg;

    // One recoded digit: sign flag and magnitude 0..8.
    typedef struct packed {
        logic       neg;
        logic [3:0] mag;
    } digit_t;

    // Number of words left after one level of 3:2 compression.
    function automatic int csa_next(input int cnt);
        return 2 * (cnt / 3) + (cnt % 3);
    endfunction

    // Number of compression levels needed to reach two words.
    function automatic int csa_levels(input int cnt);
        int c;
        int l;
        c = cnt;
        l = 0;
        while (c > 2) begin
            c = csa_next(c);
            l++;
        end
        return l;
    endfunction

    // Word count at the input of a given level.
    function automatic int csa_count(input int cnt, input int lvl);
        int c;
        c = cnt;
        for (int l = 0; l < lvl; l++) c = csa_next(c);
        return c;
    endfunction

endpackage

// File: rtl/booth_r16_recode.sv
// Splits the multiplier into 4-bit groups and turns each group,
// together with the top bit of the group below, into a signed digit
// in -8..+8. Also emits the unsigned recoding carry (top operand bit).
// Assumes N is a multiple of 4. Purely combinational.
module booth_r16_recode
    import booth_r16_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] y_i,
    output digit_t       dig_o [N/4],
    output logic         carry_o
);
    localparam int D  = N / 4;
    localparam int PW = 2 * N;

    logic [N:0] y_ext;

    // Append the implicit zero below the least significant group.
    assign y_ext = {y_i, 1'b0};

    // The top bit carries weight -8 in the last digit, so it returns as +2^N.
    assign carry_o = y_i[N-1];

    for (genvar i = 0; i < D; i++) begin : g_digit
        logic [4:0] grp;
        logic [3:0] pos;

        assign grp = y_ext[4*i+4 : 4*i];

        // Positive part of the digit: 4,2,1 weights plus the borrowed bit.
        assign pos = {1'b0, grp[3:1]} + {3'b000, grp[0]};

        // Apply the -8 weight of the group's top bit and form sign/magnitude.
        always_comb begin
            if (grp[4]) begin
                dig_o[i].mag = 4'd8 - pos;
                dig_o[i].neg = (pos != 4'd8);
            end else begin
                dig_o[i].mag = pos;
                dig_o[i].neg = 1'b0;
            end
        end

        // R4: a negative digit never has zero magnitude.
        assert_neg_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dig_o[i].neg |-> (dig_o[i].mag != 4'd0));
    end

    // Rebuilds the operand from digits and carry, modulo 2^(2N).
    function automatic logic [PW-1:0] rebuild(input digit_t d [D], input logic c);
        logic [PW-1:0] acc;
        logic [PW-1:0] term;
        acc = '0;
        for (int k = 0; k < D; k++) begin
            term = PW'(d[k].mag) << (4 * k);
            acc  = d[k].neg ? (acc - term) : (acc + term);
        end
        acc = acc + (PW'(c) << N);
        return acc;
    endfunction

    // R4/R5: digits and carry together reproduce the multiplier exactly.
    assert_digit_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rebuild(dig_o, carry_o) == PW'(y_i));

endmodule

// File: rtl/booth_r16_multiples.sv
// Forms the odd multiples 3X, 5X and 7X of the multiplicand with one
// adder each, and the top correction row: the sign compensation
// constant of all digit rows, plus X*2^N when the recoding carry is set.
// Assumes N is a multiple of 4. Purely combinational.
module booth_r16_multiples #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         x_i,
    input  logic                 carry_i,
    output logic [N+2:0]         m1_o,
    output logic [N+2:0]         m3_o,
    output logic [N+2:0]         m5_o,
    output logic [N+2:0]         m7_o,
    output logic [2*N-1:0]       top_o
);
    localparam int D  = N / 4;
    localparam int MW = N + 3;
    localparam int PW = 2 * N;

    // Sum of -2^(MW+4i) over all rows: pays back the inverted sign bits.
    function automatic logic [PW-1:0] sign_comp();
        logic [PW-1:0] k;
        k = '0;
        for (int i = 0; i < D; i++) k = k - (PW'(1) << (MW + 4 * i));
        return k;
    endfunction

    localparam logic [PW-1:0] SIGN_K = sign_comp();

    logic [PW-1:0] top_with_x;

    // Widen X so that 8X still fits.
    assign m1_o = MW'(x_i);

    // Odd multiples, each one carry-propagate addition or subtraction.
    always_comb begin
        m3_o = m1_o + (m1_o << 1);
        m5_o = m1_o + (m1_o << 2);
        m7_o = (m1_o << 3) - m1_o;
    end

    // Correction row with and without the carry copy of X.
    assign top_with_x = {x_i, {N{1'b0}}} + SIGN_K;

    // Pick the correction row according to the recoding carry.
    assign top_o = carry_i ? top_with_x : SIGN_K;

    // R6: consecutive odd multiples are evenly spaced by 2X.
    assert_odd_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((m7_o - m5_o) == (m3_o - m1_o)) && ((m5_o - m3_o) == (m1_o << 1)));

endmodule

// File: rtl/booth_r16_ppgen.sv
// Builds the partial product array. Each digit picks a multiple, which
// is inverted when the digit is negative, with an inverted sign bit on
// top. The +1 of each negation sits in the free low columns of the
// next row. The last row holds the correction word and the final +1.
// Assumes multiples come from booth_r16_multiples. Combinational.
module booth_r16_ppgen
    import booth_r16_pkg::*;
#(
    parameter int N = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N+2:0]   m1_i,
    input  logic [N+2:0]   m3_i,
    input  logic [N+2:0]   m5_i,
    input  logic [N+2:0]   m7_i,
    input  digit_t         dig_i [N/4],
    input  logic [2*N-1:0] top_i,
    output logic [2*N-1:0] rows_o [N/4+1]
);
    localparam int D  = N / 4;
    localparam int MW = N + 3;
    localparam int PW = 2 * N;

    for (genvar i = 0; i < D; i++) begin : g_row
        logic [MW-1:0] mag_val;
        logic [MW:0]   field;
        logic [PW-1:0] inc_bit;

        // Select the multiple named by the digit magnitude.
        always_comb begin
            case (dig_i[i].mag)
                4'd1:    mag_val = m1_i;
                4'd2:    mag_val = m1_i << 1;
                4'd3:    mag_val = m3_i;
                4'd4:    mag_val = m1_i << 2;
                4'd5:    mag_val = m5_i;
                4'd6:    mag_val = m3_i << 1;
                4'd7:    mag_val = m7_i;
                4'd8:    mag_val = m1_i << 3;
                default: mag_val = '0;
            endcase
        end

        // Ones' complement for negative digits, inverted sign on top.
        assign field = {~dig_i[i].neg, dig_i[i].neg ? ~mag_val : mag_val};

        // Negation increment of the previous digit, in this row's low hole.
        if (i == 0) begin : g_first
            assign inc_bit = '0;
        end else begin : g_rest
            assign inc_bit = PW'(dig_i[i-1].neg) << (4 * (i - 1));
        end

        // Place the row at its digit weight.
        assign rows_o[i] = (PW'(field) << (4 * i)) | inc_bit;

        // R6: the selected word is exactly magnitude times the multiplicand.
        assert_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mag_val == (MW'(dig_i[i].mag) * m1_i));
    end

    // Last row: correction word plus the increment of the top digit.
    assign rows_o[D] = top_i | (PW'(dig_i[D-1].neg) << (4 * (D - 1)));

endmodule

// File: rtl/booth_r16_csa_tree.sv
// Reduces ROWS words to a sum word and a carry word with levels of
// 3:2 carry-save adders. Words left over at a level pass straight on.
// Assumes ROWS >= 3. Combinational. The results are taken modulo 2^W.
module booth_r16_csa_tree
    import booth_r16_pkg::*;
#(
    parameter int W    = 128,
    parameter int ROWS = 17
) (
    input  logic [W-1:0] rows_i [ROWS],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    localparam int LV = csa_levels(ROWS);

    logic [W-1:0] lvl_q [LV+1][ROWS];

    // Level 0 is the incoming array.
    for (genvar k = 0; k < ROWS; k++) begin : g_in
        assign lvl_q[0][k] = rows_i[k];
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int CIN  = csa_count(ROWS, l);
        localparam int G    = CIN / 3;
        localparam int COUT = csa_next(CIN);

        for (genvar g = 0; g < G; g++) begin : g_csa
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic [W-1:0] c;
            logic [W-1:0] maj;

            assign a = lvl_q[l][3*g];
            assign b = lvl_q[l][3*g+1];
            assign c = lvl_q[l][3*g+2];

            // Full adder per column: majority is the carry.
            assign maj = (a & b) | (a & c) | (b & c);

            assign lvl_q[l+1][2*g]   = a ^ b ^ c;
            assign lvl_q[l+1][2*g+1] = {maj[W-2:0], 1'b0};
        end

        // Words not grouped at this level are forwarded.
        for (genvar r = 0; r < CIN % 3; r++) begin : g_pass
            assign lvl_q[l+1][2*G+r] = lvl_q[l][3*G+r];
        end

        // Slots no longer in use are tied low.
        for (genvar k = COUT; k < ROWS; k++) begin : g_zero
            assign lvl_q[l+1][k] = '0;
        end
    end

    assign sum_o = lvl_q[LV][0];
    assign cry_o = lvl_q[LV][1];

endmodule

// File: rtl/booth_r16_mul.sv
// Three-stage unsigned multiplier using radix-16 signed-digit recoding.
// Stage 1 recodes the multiplier and forms the odd multiples. Stage 2
// selects the partial products and compresses them to two words.
// Stage 3 adds the two words. The valid flag runs alongside.
// Assumes N is a multiple of 4. A new pair may enter every cycle.
module booth_r16_mul
    import booth_r16_pkg::*;
#(
    parameter int N = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic           valid_o,
    output logic [2*N-1:0] prod_o
);
    localparam int D    = N / 4;
    localparam int MW   = N + 3;
    localparam int PW   = 2 * N;
    localparam int ROWS = D + 1;

    // Stage 1 signals.
    digit_t        dig_c [D];
    logic          carry_c;
    logic [MW-1:0] m1_c, m3_c, m5_c, m7_c;
    logic [PW-1:0] top_c;

    logic          s1_valid;
    digit_t        s1_dig [D];
    logic [MW-1:0] s1_m1, s1_m3, s1_m5, s1_m7;
    logic [PW-1:0] s1_top;

    // Stage 2 signals.
    logic [PW-1:0] rows_c [ROWS];
    logic [PW-1:0] sum_c, cry_c;

    logic          s2_valid;
    logic [PW-1:0] s2_sum, s2_cry;

    booth_r16_recode #(.N(N)) u_recode (
        .clk     (clk),
        .rst_n   (rst_n),
        .y_i     (b_i),
        .dig_o   (dig_c),
        .carry_o (carry_c)
    );

    booth_r16_multiples #(.N(N)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_i     (a_i),
        .carry_i (carry_c),
        .m1_o    (m1_c),
        .m3_o    (m3_c),
        .m5_o    (m5_c),
        .m7_o    (m7_c),
        .top_o   (top_c)
    );

    // Stage 1 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= valid_i;
    end

    // Stage 1 data: digits, multiples and correction row.
    always_ff @(posedge clk) begin
        s1_dig <= dig_c;
        s1_m1  <= m1_c;
        s1_m3  <= m3_c;
        s1_m5  <= m5_c;
        s1_m7  <= m7_c;
        s1_top <= top_c;
    end

    booth_r16_ppgen #(.N(N)) u_ppgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .m1_i   (s1_m1),
        .m3_i   (s1_m3),
        .m5_i   (s1_m5),
        .m7_i   (s1_m7),
        .dig_i  (s1_dig),
        .top_i  (s1_top),
        .rows_o (rows_c)
    );

    booth_r16_csa_tree #(.W(PW), .ROWS(ROWS)) u_tree (
        .rows_i (rows_c),
        .sum_o  (sum_c),
        .cry_o  (cry_c)
    );

    // Stage 2 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= s1_valid;
    end

    // Stage 2 data: redundant sum/carry pair.
    always_ff @(posedge clk) begin
        s2_sum <= sum_c;
        s2_cry <= cry_c;
    end

    // Stage 3 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= s2_valid;
    end

    // Stage 3 data: final carry-propagate addition.
    always_ff @(posedge clk) begin
        prod_o <= s2_sum + s2_cry;
    end

    // R2: each stage passes the valid flag on one cycle later.
    assert_stage1_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> s1_valid);
    assert_stage1_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !s1_valid);
    assert_stage3_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> valid_o);

    // R3: reset clears the output flag on the following edge.
    assert_reset_idle_R3: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

endmodule

// File: tb/booth_r16_mul_tb.sv
module booth_r16_mul_tb;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           valid_i = 1'b0;
    logic [N-1:0]   a_i = '0;
    logic [N-1:0]   b_i = '0;
    logic           valid_o;
    logic [2*N-1:0] prod_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [2*N-1:0] exp_q [$];
    int             cyc_q [$];
    string          tag_q [$];

    booth_r16_mul #(.N(N)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .valid_o (valid_o),
        .prod_o  (prod_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pop and compare each result away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R3 unexpected valid_o: actual=1 expected=0");
            end else begin
                logic [2*N-1:0] e;
                int             c;
                string          t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (prod_o !== e) begin
                    n_bad++;
                    $display("FAIL %s product: actual=%h expected=%h", t, prod_o, e);
                end
                n_cmp++;
                if (cyc - c != 3) begin
                    n_bad++;
                    $display("FAIL R2 latency: actual=%0d expected=3", cyc - c);
                end
            end
        end
    end

    // Driver: present one pair and queue its expected product.
    task automatic send(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        @(negedge clk);
        valid_i = 1'b1;
        a_i     = a;
        b_i     = b;
        exp_q.push_back((2*N)'(a) * (2*N)'(b));
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_i = 1'b0;
            a_i     = {$urandom, $urandom};
            b_i     = {$urandom, $urandom};
        end
    endtask

    // Same multiplier against several multiplicands.
    task automatic sweep_b(input logic [N-1:0] b, input string tag);
        send({N{1'b1}}, b, tag);
        send(64'h0000_0000_0000_0001, b, tag);
        send({$urandom, $urandom}, b, tag);
        send(64'h8000_0000_0000_0000, b, tag);
        idle(1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R3: held in reset with a pair present, no output.
        valid_i = 1'b1;
        a_i     = 64'h1234;
        b_i     = 64'h5678;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (valid_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R3 valid_o in reset: actual=%b expected=0", valid_o);
        end
        valid_i = 1'b0;
        rst_n   = 1'b1;
        // R3: idle after reset, still no output.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            n_cmp++;
            if (valid_o !== 1'b0) begin
                n_bad++;
                $display("FAIL R3 valid_o idle: actual=%b expected=0", valid_o);
            end
        end

        // R7: zero, one and all-ones operands.
        send('0, {$urandom, $urandom}, "R7");
        send({$urandom, $urandom}, '0, "R7");
        send(64'h1, {$urandom, $urandom}, "R7");
        send({$urandom, $urandom}, 64'h1, "R7");
        send({N{1'b1}}, {N{1'b1}}, "R7");
        send({N{1'b1}}, 64'h1, "R7");
        idle(2);

        // R4: +8 digits (0x7F7F..) and -8 digits (0x0808.., 0x8080..).
        sweep_b(64'h7F7F_7F7F_7F7F_7F7F, "R4");
        sweep_b(64'h0808_0808_0808_0808, "R4");
        sweep_b(64'h8080_8080_8080_8080, "R4");

        // R5: recoding carry from the top multiplier bit.
        sweep_b({N{1'b1}}, "R5");
        sweep_b(64'h8000_0000_0000_0000, "R5");
        sweep_b(64'h7FFF_FFFF_FFFF_FFFF, "R5");

        // R6: one digit value everywhere, each multiple and its negation.
        sweep_b(64'h3333_3333_3333_3333, "R6");
        sweep_b(64'h5555_5555_5555_5555, "R6");
        sweep_b(64'h7777_7777_7777_7777, "R6");
        sweep_b(64'h6666_6666_6666_6666, "R6");
        sweep_b(64'hDDDD_DDDD_DDDD_DDDD, "R6");
        sweep_b(64'hBBBB_BBBB_BBBB_BBBB, "R6");
        sweep_b(64'h9999_9999_9999_9999, "R6");
        sweep_b(64'hCCCC_CCCC_CCCC_CCCC, "R6");
        sweep_b(64'h2222_2222_2222_2222, "R6");
        sweep_b(64'h4444_4444_4444_4444, "R6");

        // R2: back-to-back burst.
        for (int k = 0; k < 24; k++) send({$urandom, $urandom}, {$urandom, $urandom}, "R2");
        idle(1);

        // R1: random stream with random gaps.
        for (int k = 0; k < 300; k++) begin
            send({$urandom, $urandom}, {$urandom, $urandom}, "R1");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end

        idle(8);
        // R2: every queued pair was returned.
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing results: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule